// File: doc/BRIEF.md
# Adder-Centric Streaming ALU

This block is an 8-bit arithmetic and logic unit in which every function passes through a single final adder. It works in three steps. First, a small bitwise front end forms the AND and XOR terms of the two operands. Next, two operand multiplexers choose what the adder sees. Last, the adder produces the result. The unit contains no OR gate: OR is produced as the sum of the AND term and the XOR term, which never carry into each other.

The operation code is four bits wide, and each bit drives a multiplexer select or the carry-in directly, so the code can be taken from an instruction word with no decoder in between. The required functions are add, subtract, AND, OR, XOR, pass-through of B and increment of A. The remaining codes give other combinations of the same terms. An example is (A^B)+1. A wider system is free to reuse those codes for instructions that do not need the ALU.

Operands enter on a valid/ready stream, and results leave on a second valid/ready stream through one output register. The upstream side may present a new operation in every cycle in which `in_ready` is high. While a result is waiting (`out_valid` high and `out_ready` low), `in_ready` stays low and the held result does not change. No carry, flag or status is kept.

Top module: `mux_adder_alu`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: An operation is taken in on a rising edge where `in_valid` and `in_ready` are both 1. Its result appears with `out_valid` high right after that edge. `in_ready` is 0 whenever a result is held with `out_ready` low.
- R3: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_res` stays unchanged on the next edge.
- R4: The fields of `in_op` act as follows. Bit 3 selects the pairing: the left term is A^B rather than A, and the right base is A&B rather than B. Bit 2 forces the left term to zero. Bit 1 enables the right term, which is zero when bit 1 is 0. Bit 0 inverts the right term and sets the carry-in.
- R5: Code 0x2 gives (A+B) mod 256.
- R6: Code 0x3 gives (A-B) mod 256, formed as A + ~B + 1.
- R7: Code 0x1 gives (A+1) mod 256, so 0xFF becomes 0x00.
- R8: Code 0xA gives A|B, formed by adding the AND and XOR terms.
- R9: Code 0x8 gives A^B, and code 0xE gives A&B.
- R10: Code 0x6 passes B through unchanged.
- R11: Every one of the 16 codes gives (L + R + c) mod 256, with L, R and c as defined in R4. For example, code 0x9 gives ((A^B)+1) mod 256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_a | input | 8 | Operand A (accumulator side) |
| in_b | input | 8 | Operand B (bus side) |
| in_op | input | 4 | Function code, fields per R4 |
| out_valid | output | 1 | Result held and offered |
| out_ready | input | 1 | Downstream takes the result |
| out_res | output | 8 | Result, modulo 256 |

## Verification
On every cycle, the assertions check the handshake: that an accepted operation leads to a valid result one edge later, that input is refused while a stalled result is held, and that a stalled result is stable. They also check the values produced by add, subtract, OR and increment against the operands sampled at acceptance. Only the bench's scenarios can show that all sixteen codes follow the shared formula across corner operands (0x00, 0xFF, 0x80, 0x7F, 0x01) and random operands. The same holds for in-order delivery under irregular back-pressure and for the state right after reset.

// File: rtl/mux_alu_pkg.sv
package mux_alu_pkg;
  localparam int unsigned OP_W = 4;

  // Field layout of the function code; each bit steers the datapath directly.
  typedef struct packed {
    logic pair_mode;  // left = A^B, right base = A&B
    logic left_zero;  // force left term to zero
    logic right_en;   // enable right term
    logic right_inv;  // invert right term and set carry-in
  } alu_ctl_t;
endpackage

// File: rtl/alu_term_stage.sv
module alu_term_stage #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] and_t,
  output logic [W-1:0] xor_t
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign and_t[i] = a[i] & b[i];
    assign xor_t[i] = a[i] ^ b[i];
  end
endmodule

// File: rtl/alu_operand_sel.sv
module alu_operand_sel
  import mux_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  alu_ctl_t     ctl,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] and_t,
  input  logic [W-1:0] xor_t,
  output logic [W-1:0] left_op,
  output logic [W-1:0] right_op,
  output logic         cin
);
  logic [W-1:0] left_pre;
  logic [W-1:0] right_base;
  logic [W-1:0] right_pol;

  always_comb begin
    left_pre   = ctl.pair_mode ? xor_t : a;
    left_op    = ctl.left_zero ? '0 : left_pre;
    right_base = ctl.pair_mode ? and_t : b;
    right_pol  = ctl.right_inv ? ~right_base : right_base;
    right_op   = ctl.right_en ? right_pol : '0;
    cin        = ctl.right_inv;
  end
endmodule

// File: rtl/alu_ripple_add.sv
module alu_ripple_add #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum
);
  logic [W-1:0] carry;

  assign carry[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum[i] = x[i] ^ y[i] ^ carry[i];
    if (i < W - 1) begin : g_chain
      assign carry[i+1] = (x[i] & y[i]) | (carry[i] & (x[i] ^ y[i]));
    end
  end
endmodule

// File: rtl/alu_out_reg.sv
module alu_out_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  logic         vld_q;
  logic [W-1:0] dat_q;

  assign up_ready = !vld_q || dn_ready;
  assign dn_valid = vld_q;
  assign dn_data  = dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (up_ready) begin
      vld_q <= up_valid;
      if (up_valid) dat_q <= up_data;
    end
  end
endmodule

// File: rtl/mux_adder_alu.sv
module mux_adder_alu
  import mux_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [W-1:0]    in_a,
  input  logic [W-1:0]    in_b,
  input  logic [OP_W-1:0] in_op,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [W-1:0]    out_res
);
  alu_ctl_t     ctl;
  logic [W-1:0] and_t, xor_t;
  logic [W-1:0] left_op, right_op;
  logic         cin;
  logic [W-1:0] sum;

  assign ctl = alu_ctl_t'(in_op);

  alu_term_stage #(.W(W)) i_terms (
    .a(in_a), .b(in_b), .and_t(and_t), .xor_t(xor_t)
  );

  alu_operand_sel #(.W(W)) i_sel (
    .ctl(ctl), .a(in_a), .b(in_b), .and_t(and_t), .xor_t(xor_t),
    .left_op(left_op), .right_op(right_op), .cin(cin)
  );

  alu_ripple_add #(.W(W)) i_add (
    .x(left_op), .y(right_op), .cin(cin), .sum(sum)
  );

  alu_out_reg #(.W(W)) i_oreg (
    .clk(clk), .rst_n(rst_n),
    .up_valid(in_valid), .up_ready(in_ready), .up_data(sum),
    .dn_valid(out_valid), .dn_ready(out_ready), .dn_data(out_res)
  );
endmodule

// File: rtl/mux_adder_alu_chk.sv
module mux_adder_alu_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] in_a,
  input logic [W-1:0] in_b,
  input logic [3:0]   in_op,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_res
);
  logic take;
  assign take = in_valid && in_ready;

  a_r2_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  a_r2_refuse_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_res)));

  a_r5_add_value: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_op == 4'h2) |=> out_res == W'($past(in_a) + $past(in_b)));

  a_r6_sub_value: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_op == 4'h3) |=> out_res == W'($past(in_a) - $past(in_b)));

  a_r7_inc_value: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_op == 4'h1) |=> out_res == W'($past(in_a) + 1'b1));

  a_r8_or_value: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_op == 4'hA) |=> out_res == ($past(in_a) | $past(in_b)));
endmodule

bind mux_adder_alu mux_adder_alu_chk #(.W(W)) i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_a(in_a), .in_b(in_b), .in_op(in_op), .out_valid(out_valid),
  .out_ready(out_ready), .out_res(out_res)
);

// File: tb/test_mux_adder_alu.sv
module test_mux_adder_alu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_a = '0;
  logic [7:0] in_b = '0;
  logic [3:0] in_op = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_res;

  int checks = 0;
  int errors = 0;
  int bp_mode = 0;  // 0 always ready, 1 irregular, 2 stalled
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       prev_stall = 1'b0;
  logic [7:0] prev_val = '0;

  always #2 clk = ~clk;

  mux_adder_alu i_mux_adder_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_op(in_op), .out_valid(out_valid),
    .out_ready(out_ready), .out_res(out_res)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  // Formula of R11 / field meanings of R4.
  function automatic logic [7:0] formula(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b);
    logic [7:0] l, rb, r;
    l  = op[2] ? 8'h00 : (op[3] ? (a ^ b) : a);
    rb = op[3] ? (a & b) : b;
    r  = op[1] ? (op[0] ? ~rb : rb) : 8'h00;
    return 8'(l + r + {7'd0, op[0]});
  endfunction

  task automatic send(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                      input logic [7:0] expv, input string req);
    bit taken = 1'b0;
    @(posedge clk); #1;
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
    while (!taken) begin
      @(negedge clk);
      if (in_ready) begin
        exp_q.push_back(expv);
        tag_q.push_back(req);
        taken = 1'b1;
      end
    end
  endtask

  task automatic idle();
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  // Downstream back-pressure driver.
  always @(posedge clk) begin
    #1;
    if (bp_mode == 0) out_ready = 1'b1;
    else if (bp_mode == 2) out_ready = 1'b0;
    else out_ready = ($urandom_range(0, 3) != 0);
  end

  // Monitor: pops the scoreboard and watches held results.
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)  // R3
        check(out_valid && out_res == prev_val, "R3", int'(out_res), int'(prev_val));
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2", int'(out_res), -1);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_res == e, t, int'(out_res), int'(e));
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_val   = out_res;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] corners[5];
    corners = '{8'h00, 8'hFF, 8'h80, 8'h7F, 8'h01};

    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    check(out_valid == 1'b0, "R1", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1", int'(in_ready), 1);

    // R2: accepted item appears next edge; refused while stalled
    bp_mode = 2;
    send(4'h2, 8'h12, 8'h34, 8'h46, "R5");
    @(posedge clk); #1;
    in_valid = 1'b1; in_op = 4'h6; in_a = 8'h00; in_b = 8'h99;
    @(negedge clk);
    check(out_valid == 1'b1, "R2", int'(out_valid), 1);
    check(in_ready == 1'b0, "R2", int'(in_ready), 0);
    @(negedge clk);
    check(in_ready == 1'b0, "R2", int'(in_ready), 0);
    in_valid = 1'b0;
    bp_mode = 0;
    idle();

    // Named functions over corner operands
    foreach (corners[i]) begin
      foreach (corners[j]) begin
        logic [7:0] a, b;
        a = corners[i];
        b = corners[j];
        send(4'h2, a, b, 8'(a + b), "R5");
        send(4'h3, a, b, 8'(a - b), "R6");
        send(4'h1, a, b, 8'(a + 8'd1), "R7");
        send(4'hA, a, b, a | b, "R8");
        send(4'h8, a, b, a ^ b, "R9");
        send(4'hE, a, b, a & b, "R9");
        send(4'h6, a, b, b, "R10");
      end
    end

    // R4 / R11: every code, corner and random operands, irregular back-pressure
    bp_mode = 1;
    for (int k = 0; k < 16; k++) begin
      send(4'(k), 8'hFF, 8'h80, formula(4'(k), 8'hFF, 8'h80), "R11");
      send(4'(k), 8'h80, 8'h7F, formula(4'(k), 8'h80, 8'h7F), "R4");
    end
    send(4'h9, 8'h0F, 8'hF0, 8'h00, "R11");  // (A^B)+1 wraps
    for (int n = 0; n < 400; n++) begin
      logic [3:0] op;
      logic [7:0] a, b;
      op = 4'($urandom_range(0, 15));
      a  = 8'($urandom_range(0, 255));
      b  = 8'($urandom_range(0, 255));
      send(op, a, b, formula(op, a, b), "R11");
    end
    idle();
    bp_mode = 0;

    while (exp_q.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule